// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This block holds, for each of a small group of processors, one pending flag for an inter-processor interrupt and one pending flag for a periodic timer interrupt. Each flag drives its own interrupt line to its processor. The inter-processor line is the higher-priority level and the timer line is the lower-priority level. Software posts and retires inter-processor interrupts, and retires timer interrupts, by writing processor masks. A periodic tick input sets the timer flag of every processor that is present.

Writes go through a two-bit register select. Select 0 is a combined control register. Through three independent fields, one write to it can post inter-processor interrupts, retire inter-processor interrupts and retire timer interrupts, each for any subset of processors. Selects 1, 2 and 3 each perform one of those operations and take bits 3:0 of the written word as the processor mask. Malformed writes raise a one-cycle error pulse. Redundant posts and clears raise a one-cycle warning pulse. A read of the control register returns the accessing processor's ID together with both pending vectors.

Top module: `ipi_timer_irq_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, every inter-processor flag, every timer flag, `err_pulse` and `warn_pulse` are 0.
- R2: A write with select 0 acts on three fields in the same cycle. Bits 15:12 post inter-processor interrupts, bits 11:8 retire them, and bits 7:4 retire timer interrupts. If one write both posts and retires the inter-processor flag of the same processor, the flag ends cleared.
- R3: A select-0 write whose only set bit among the decoded bits is bit 28 is accepted. It changes no flag and raises no error.
- R4: A select-0 write with none of bits 28, 15:12, 11:8 or 7:4 set raises `err_pulse` in the following cycle and changes no flag.
- R5: Posting an inter-processor interrupt to a processor whose flag is already set, or retiring one that is not set, leaves that flag unchanged and raises `warn_pulse` in the following cycle.
- R6: A cycle with `tick` high sets the timer flag of every present processor at the next edge.
- R7: `ipi_irq[n]` equals processor n's inter-processor flag, and `tmr_irq[n]` equals its timer flag. Both update at the clock edge that applies the change.
- R8: Select 1 posts inter-processor interrupts, select 2 retires them, and select 3 retires timer interrupts. Each uses `wr_data[3:0]` as the processor mask.
- R9: A write with select 1, 2 or 3 whose `wr_data[3:0]` is zero raises `err_pulse` and changes no flag.
- R10: A read with select 0 returns the `cpu_id` input in bits 1:0, the inter-processor flags in bits 11:8 and the timer flags in bits 7:4, with all other bits zero. A read with any other select returns zero. The read data is combinational in `rd_en`.
- R11: Mask bits at or above the parameter `NUM_CPU` (default 3) have no effect and raise no warning. The flags and lines of absent processors stay 0.
- R12: If a tick and a timer retire hit the same processor in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 post, 2 retire IPI, 3 retire timer |
| wr_data | input | 32 | Write data |
| cpu_id | input | 2 | ID of the accessing processor |
| tick | input | 1 | Periodic timer event |
| rd_data | output | 32 | Read data |
| ipi_irq | output | 4 | Inter-processor interrupt line per processor |
| tmr_irq | output | 4 | Timer interrupt line per processor |
| err_pulse | output | 1 | Malformed write seen in the previous cycle |
| warn_pulse | output | 1 | Redundant post or retire seen in the previous cycle |

## Verification
The hardest case to reach from the ports is a single control write that both posts and retires the same processor's inter-processor flag while that flag is already set. The result is then decided by the priority order and by the warning logic together. The stimulus table first builds up a known pending pattern through earlier rows, and only then issues that combined write. The tick-against-retire collision also needs two inputs aligned on one edge, so a directed task drives both in the same cycle.

// File: rtl/ipi_tmr_pkg.sv
// Package: shared register selects, field positions and sizing for the
// inter-processor and timer interrupt unit.
package ipi_tmr_pkg;
    localparam int MAX_CPU  = 4;
    localparam int DATA_W   = 32;
    localparam int CPU_ID_W = $clog2(MAX_CPU);

    // Field positions inside the combined control word.
    localparam int POST_LSB   = 12;
    localparam int RETIRE_LSB = 8;
    localparam int TCLR_LSB   = 4;
    localparam int ACK_BIT    = 28;

    typedef enum logic [1:0] {
        SEL_CTRL     = 2'd0,
        SEL_POST     = 2'd1,
        SEL_RETIRE   = 2'd2,
        SEL_TMR_CLR  = 2'd3
    } regsel_e;
endpackage

// File: rtl/ipi_tmr_wr_decode.sv
// Module: write decoder. Turns one register write into three processor
// masks (post, retire, timer clear) and a malformed-write flag.
// Assumes: purely combinational; masks are zero when wr_en is low.
module ipi_tmr_wr_decode
    import ipi_tmr_pkg::*;
(
    input  logic                wr_en,
    input  logic [1:0]          reg_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [MAX_CPU-1:0]  post_mask,
    output logic [MAX_CPU-1:0]  retire_mask,
    output logic [MAX_CPU-1:0]  tclr_mask,
    output logic                bad_wr
);
    logic [MAX_CPU-1:0] low_mask;
    logic unused_hi_bits;

    assign low_mask = wr_data[MAX_CPU-1:0];
    assign unused_hi_bits = ^{wr_data[DATA_W-1:ACK_BIT+1], wr_data[ACK_BIT-1:POST_LSB+MAX_CPU]};

    // Route the write fields to masks by register select.
    always_comb begin
        post_mask   = '0;
        retire_mask = '0;
        tclr_mask   = '0;
        bad_wr      = 1'b0;
        if (wr_en) begin
            unique case (regsel_e'(reg_sel))
                SEL_CTRL: begin
                    post_mask   = wr_data[POST_LSB   +: MAX_CPU];
                    retire_mask = wr_data[RETIRE_LSB +: MAX_CPU];
                    tclr_mask   = wr_data[TCLR_LSB   +: MAX_CPU];
                    bad_wr      = !(wr_data[ACK_BIT] || (|post_mask) ||
                                    (|retire_mask) || (|tclr_mask));
                end
                SEL_POST: begin
                    post_mask = low_mask;
                    bad_wr    = (low_mask == '0);
                end
                SEL_RETIRE: begin
                    retire_mask = low_mask;
                    bad_wr      = (low_mask == '0);
                end
                default: begin
                    tclr_mask = low_mask;
                    bad_wr    = (low_mask == '0);
                end
            endcase
        end
    end
endmodule

// File: rtl/ipi_tmr_pend_bank.sv
// Module: bank of per-processor pending flags with a set and a clear mask.
// SET_WINS picks the collision rule: 1 lets a set beat a clear, 0 applies
// the set first and the clear after it. Flags of absent processors are
// tied to zero.
module ipi_tmr_pend_bank
    import ipi_tmr_pkg::*;
#(
    parameter int N_CPU    = 3,
    parameter bit SET_WINS = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAX_CPU-1:0] set_i,
    input  logic [MAX_CPU-1:0] clr_i,
    output logic [MAX_CPU-1:0] pend_o
);
    localparam logic [MAX_CPU-1:0] PRES = MAX_CPU'((1 << N_CPU) - 1);

    for (genvar g = 0; g < MAX_CPU; g++) begin : g_cpu
        if (g < N_CPU) begin : g_live
            logic flag_q;
            // Update one processor's flag under the chosen collision rule.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (SET_WINS)
                    flag_q <= (flag_q & ~clr_i[g]) | set_i[g];
                else
                    flag_q <= (flag_q | set_i[g]) & ~clr_i[g];
            end
            assign pend_o[g] = flag_q;
        end else begin : g_absent
            logic unused_in;
            assign unused_in = set_i[g] ^ clr_i[g];
            assign pend_o[g] = 1'b0;
        end
    end

    // R2: a lone set lands on the next edge
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        |(set_i & ~clr_i & PRES) |=>
        ((pend_o & $past(set_i & ~clr_i & PRES)) == $past(set_i & ~clr_i & PRES)));

    // R2: a lone clear lands on the next edge
    a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & ~set_i & PRES) |=>
        ((pend_o & $past(clr_i & ~set_i & PRES)) == '0));

    if (SET_WINS) begin : g_setwins_chk
        // R12: on a collision the set survives
        a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            |(set_i & clr_i & PRES) |=>
            ((pend_o & $past(set_i & clr_i & PRES)) == $past(set_i & clr_i & PRES)));
    end
endmodule

// File: rtl/ipi_timer_irq_unit.sv
// Module: inter-processor and timer interrupt unit (top). Decodes writes,
// keeps the two pending banks, flags malformed and redundant operations,
// and serves the combined control-register read.
// Assumes: NUM_CPU <= MAX_CPU; one write per cycle; tick is a one-cycle pulse.
module ipi_timer_irq_unit
    import ipi_tmr_pkg::*;
#(
    parameter int NUM_CPU = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [1:0]           reg_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [CPU_ID_W-1:0]  cpu_id,
    input  logic                 tick,
    output logic [DATA_W-1:0]    rd_data,
    output logic [MAX_CPU-1:0]   ipi_irq,
    output logic [MAX_CPU-1:0]   tmr_irq,
    output logic                 err_pulse,
    output logic                 warn_pulse
);
    localparam logic [MAX_CPU-1:0] PRES = MAX_CPU'((1 << NUM_CPU) - 1);

    logic [MAX_CPU-1:0] post_mask, retire_mask, tclr_mask, tick_mask;
    logic               bad_wr, redundant;
    logic               err_q, warn_q;

    ipi_tmr_wr_decode u_dec (
        .wr_en       (wr_en),
        .reg_sel     (reg_sel),
        .wr_data     (wr_data),
        .post_mask   (post_mask),
        .retire_mask (retire_mask),
        .tclr_mask   (tclr_mask),
        .bad_wr      (bad_wr)
    );

    ipi_tmr_pend_bank #(.N_CPU(NUM_CPU), .SET_WINS(1'b0)) u_ipi (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (post_mask),
        .clr_i  (retire_mask),
        .pend_o (ipi_irq)
    );

    assign tick_mask = tick ? PRES : '0;

    ipi_tmr_pend_bank #(.N_CPU(NUM_CPU), .SET_WINS(1'b1)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tick_mask),
        .clr_i  (tclr_mask),
        .pend_o (tmr_irq)
    );

    // Redundant post (already pending) or retire (neither pending nor posted now).
    assign redundant = |(PRES & ((post_mask & ipi_irq) |
                                 (retire_mask & ~ipi_irq & ~post_mask)));

    // Register the one-cycle error and warning pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            warn_q <= 1'b0;
        end else begin
            err_q  <= bad_wr;
            warn_q <= redundant;
        end
    end

    assign err_pulse  = err_q;
    assign warn_pulse = warn_q;

    // Assemble the combined control-register read word.
    always_comb begin
        rd_data = '0;
        if (rd_en && regsel_e'(reg_sel) == SEL_CTRL) begin
            rd_data[CPU_ID_W-1:0]           = cpu_id;
            rd_data[TCLR_LSB   +: MAX_CPU]  = tmr_irq;
            rd_data[RETIRE_LSB +: MAX_CPU]  = ipi_irq;
        end
    end

    // R4: a malformed write leaves the inter-processor flags alone
    a_r4_bad_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (ipi_irq == $past(ipi_irq)));

    // R6: a tick fills every present timer flag
    a_r6_tick_fills: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((tmr_irq & PRES) == PRES));

    // R11: absent processors never see an interrupt
    a_r11_absent_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_irq | tmr_irq) & ~PRES) == '0);
endmodule

// File: tb/ipi_timer_irq_unit_tb.sv
`timescale 1ns/1ps
module ipi_timer_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  cpu_id = 2'd0;
    logic        tick = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  ipi_irq, tmr_irq;
    logic        err_pulse, warn_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ipi_timer_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .cpu_id(cpu_id), .tick(tick),
        .rd_data(rd_data), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
        .err_pulse(err_pulse), .warn_pulse(warn_pulse)
    );

    // {sel[1:0], data[31:0], ipi[3:0], tmr[3:0], err, warn}; NUM_CPU = 3
    localparam int NV = 12;
    localparam logic [43:0] VEC [0:NV-1] = '{
        {2'd0, 32'h0000_7000, 4'h7, 4'h0, 1'b0, 1'b0},  // R2 post 0..2
        {2'd0, 32'h0000_1000, 4'h7, 4'h0, 1'b0, 1'b1},  // R5 re-post
        {2'd0, 32'h0000_0200, 4'h5, 4'h0, 1'b0, 1'b0},  // R2 retire cpu1
        {2'd0, 32'h0000_0200, 4'h5, 4'h0, 1'b0, 1'b1},  // R5 retire not pending
        {2'd0, 32'h1000_0000, 4'h5, 4'h0, 1'b0, 1'b0},  // R3 ack bit only
        {2'd0, 32'h0000_0001, 4'h5, 4'h0, 1'b1, 1'b0},  // R4 unsupported
        {2'd1, 32'h0000_0002, 4'h7, 4'h0, 1'b0, 1'b0},  // R8 post reg
        {2'd2, 32'h0000_0005, 4'h2, 4'h0, 1'b0, 1'b0},  // R8 retire reg
        {2'd2, 32'h0000_0000, 4'h2, 4'h0, 1'b1, 1'b0},  // R9 zero mask
        {2'd1, 32'h0000_0008, 4'h2, 4'h0, 1'b0, 1'b0},  // R11 absent cpu
        {2'd0, 32'h0000_4100, 4'h6, 4'h0, 1'b0, 1'b1},  // R2 post cpu2, R5 retire cpu0
        {2'd0, 32'h0000_2200, 4'h4, 4'h0, 1'b0, 1'b1}   // R2 post+retire cpu1
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_tick(input bit with_wr, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        tick = 1'b1;
        wr_en = with_wr; reg_sel = s; wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [1:0] id, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = s; cpu_id = id;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ipi in reset", {28'd0, ipi_irq}, 32'h0);
        check("R1 tmr in reset", {28'd0, tmr_irq}, 32'h0);
        check("R1 pulses in reset", {30'd0, err_pulse, warn_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ipi after reset", {28'd0, ipi_irq}, 32'h0);
        rd(2'd0, 2'd2, v);
        check("R10 read id only", v, 32'h0000_0002);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][43:42], VEC[i][41:10]);
            check($sformatf("R7 ipi row %0d", i), {28'd0, ipi_irq}, {28'd0, VEC[i][9:6]});
            check($sformatf("R7 tmr row %0d", i), {28'd0, tmr_irq}, {28'd0, VEC[i][5:2]});
            check($sformatf("R4/R9 err row %0d", i), {31'd0, err_pulse}, {31'd0, VEC[i][1]});
            check($sformatf("R5 warn row %0d", i), {31'd0, warn_pulse}, {31'd0, VEC[i][0]});
        end

        // R6 tick sets all present timer flags
        pulse_tick(1'b0, 2'd0, 32'h0);
        check("R6 tick fills", {28'd0, tmr_irq}, 32'h7);
        // R2 timer-clear field of the control word
        wr(2'd0, 32'h0000_0050);
        check("R2 timer clear field", {28'd0, tmr_irq}, 32'h2);
        // R8 timer clear register
        wr(2'd3, 32'h0000_0002);
        check("R8 timer clear reg", {28'd0, tmr_irq}, 32'h0);
        // R9 zero mask on timer clear
        wr(2'd3, 32'h0000_0000);
        check("R9 zero mask err", {31'd0, err_pulse}, 32'h1);
        check("R9 zero mask no change", {28'd0, tmr_irq}, 32'h0);
        // R10 full read word
        pulse_tick(1'b0, 2'd0, 32'h0);
        rd(2'd0, 2'd1, v);
        check("R10 read word", v, 32'h0000_0471);
        // R12 tick and timer clear collide
        pulse_tick(1'b1, 2'd3, 32'h0000_0007);
        check("R12 set wins", {28'd0, tmr_irq}, 32'h7);
        // R11 absent processor mask bit on timer clear
        wr(2'd3, 32'h0000_0008);
        check("R11 absent tclr tmr", {28'd0, tmr_irq}, 32'h7);
        check("R11 absent tclr err", {31'd0, err_pulse}, 32'h0);
        // R10 other selects read zero
        rd(2'd1, 2'd3, v);
        check("R10 non-ctrl read", v, 32'h0);
        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset ipi", {28'd0, ipi_irq}, 32'h0);
        check("R1 mid reset tmr", {28'd0, tmr_irq}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule